// File: doc/BRIEF.md
# Power-of-Two Clock Enable Bank

This block turns one fast reference clock into four derived timing strobes. The channels are encoder sampling, pulse-frequency output, DAC serial clock and ADC serial clock. Each channel divides the reference by 2^N, where N is a 3-bit selector, so the ratio runs from 1 to 128. A higher N means a slower strobe. For the encoder channel, the strobe rate is the highest count rate the sampling logic can accept, because at most one count is taken per strobe.

All four selectors share one 12-bit configuration word, which the host writes through a write-enable port. All four channels take their timing from one free-running 7-bit phase counter. Each channel produces a one-cycle clock enable and a 50% duty square wave, both in the reference clock domain.

A written word first goes to a pending register. It becomes active only when the phase counter steps from 127 to 0, so a channel never produces a shortened period. The read port always shows the active word, not the pending one.

Top module: `p2div_bank`

## Requirements
- R1: While `rst_n` is low, the active and pending words are set to 2258 (octal 4322) and the phase counter is cleared. On the first cycle after release, `cfg_rdata` reads 2258, the counter is 0, and every strobe and square output is low.
- R2: The selector layout in the word is fixed. Bits [2:0] are the encoder channel (index 0), bits [5:3] the pulse-frequency channel (index 1), bits [8:6] the DAC channel (index 2) and bits [11:9] the ADC channel (index 3).
- R3: For a selector N of 1 or more, `strobe[i]` is high for exactly one cycle whenever the low N bits of the phase counter are all ones. This gives one pulse every 2^N reference cycles.
- R4: A selector of 0 holds `strobe[i]` high on every cycle and holds `square[i]` low.
- R5: For a selector N of 1 or more, `square[i]` equals bit N-1 of the phase counter. The result is a 50% duty wave with period 2^N, high during the half that ends with the strobe cycle.
- R6: A write goes to the pending register only. The active word, and so `cfg_rdata` and every output, takes the pending value at the clock edge where the counter steps from 127 to 0, and at no other edge.
- R7: If several writes land between two counter wraps, the last one is the one applied.
- R8: On the cycle where the phase counter is 127, every channel's strobe is high, whatever its selector.
- R9: Channels are independent. Changing one selector field never alters the strobe or square timing of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Write enable for the pending configuration word |
| cfg_wdata | input | 12 | Configuration word to write |
| cfg_rdata | output | 12 | Active configuration word |
| strobe | output | 4 | One-cycle clock enables, index 0 encoder, 1 pulse-frequency, 2 DAC, 3 ADC |
| square | output | 4 | 50% duty square waves, same channel order |

## Verification
Strobes and square waves are decoded without registers from the phase counter and the active word, so they are valid in the same cycle the counter holds a given value. The counter reads 0 in the first cycle after reset release. A write seen at one rising edge reaches `cfg_rdata` and the outputs only after the next 127-to-0 counter step, which can be up to 128 cycles later. The bench keeps a behavioural model whose state advances on the same rising edges as the design. It compares every output against that model at each falling edge, when both have settled for the current cycle. This makes every check land in exactly the cycle the requirements name, with no fixed delay built into the bench.

// File: rtl/p2div_pkg.sv
package p2div_pkg;
  // Number of derived channels and width of one selector field
  localparam int unsigned CH_COUNT = 4;
  localparam int unsigned SEL_W    = 3;
  // Derived widths
  localparam int unsigned CFG_W    = CH_COUNT * SEL_W;
  localparam int unsigned CNT_W    = (1 << SEL_W) - 1;
  // Reset configuration: encoder 2, pulse-frequency 2, DAC 3, ADC 4
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(2258);
endpackage

// File: rtl/p2div_phase_counter.sv
module p2div_phase_counter #(
  parameter int unsigned CNT_W = p2div_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // Last count before the counter returns to zero
  assign wrap = &cnt;
endmodule

// File: rtl/p2div_cfg_regs.sv
module p2div_cfg_regs #(
  parameter int unsigned      CFG_W     = p2div_pkg::CFG_W,
  parameter logic [CFG_W-1:0] CFG_RESET = p2div_pkg::CFG_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             wrap,
  output logic [CFG_W-1:0] active
);
  logic [CFG_W-1:0] pending;
  logic [CFG_W-1:0] pending_nxt;
  logic [CFG_W-1:0] active_nxt;

  always_comb begin
    pending_nxt = we   ? wdata   : pending;
    active_nxt  = wrap ? pending : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= CFG_RESET;
      active  <= CFG_RESET;
    end else begin
      pending <= pending_nxt;
      active  <= active_nxt;
    end
  end

  // R6: the active word only moves on the counter wrap edge
  a_r6_apply_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(wrap));
endmodule

// File: rtl/p2div_tap.sv
module p2div_tap #(
  parameter int unsigned SEL_W = p2div_pkg::SEL_W,
  parameter int unsigned CNT_W = p2div_pkg::CNT_W
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe,
  output logic             square
);
  logic [CNT_W-1:0] mask;
  logic [SEL_W-1:0] half_idx;
  logic [CNT_W-1:0] shifted;

  always_comb begin
    mask     = (CNT_W'(1) << sel) - CNT_W'(1);
    strobe   = ((cnt & mask) == mask);
    half_idx = sel - SEL_W'(1);
    shifted  = cnt >> half_idx;
    square   = (sel != '0) && shifted[0];
  end
endmodule

// File: rtl/p2div_bank.sv
module p2div_bank #(
  parameter int unsigned CH_COUNT = p2div_pkg::CH_COUNT,
  parameter int unsigned SEL_W    = p2div_pkg::SEL_W,
  parameter int unsigned CFG_W    = CH_COUNT * SEL_W,
  parameter int unsigned CNT_W    = (1 << SEL_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic [CH_COUNT-1:0] strobe,
  output logic [CH_COUNT-1:0] square
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CFG_W-1:0] active;

  p2div_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .wrap (wrap)
  );

  p2div_cfg_regs #(.CFG_W(CFG_W), .CFG_RESET(p2div_pkg::CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .wrap  (wrap),
    .active(active)
  );

  assign cfg_rdata = active;

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
    logic [SEL_W-1:0] sel;
    assign sel = active[g*SEL_W +: SEL_W];

    p2div_tap #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_tap (
      .cnt   (cnt),
      .sel   (sel),
      .strobe(strobe[g]),
      .square(square[g])
    );

    // R5: a strobe of a divided channel falls in the high half of its square wave
    a_r5_strobe_in_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe[g] && sel != '0) |-> square[g]);

    // R3: a divided channel's strobe lasts one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe[g] && sel != '0 && !wrap) |=> !strobe[g]);
  end

  // R8: all channels pulse together on the last count
  a_r8_aligned_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> &strobe);
endmodule

// File: tb/test_p2div_bank.sv
module test_p2div_bank;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_wdata;
  logic [11:0] cfg_rdata;
  logic [3:0]  strobe;
  logic [3:0]  square;

  int vectors;
  int errors;
  int cycles;
  string tag;
  bit checking;
  bit done;

  // Behavioural reference model
  int m_cnt;
  int m_active;
  int m_pending;

  p2div_bank i_p2div_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .strobe   (strobe),
    .square   (square)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt     <= 0;
      m_active  <= 2258;
      m_pending <= 2258;
    end else begin
      if (m_cnt == 127) m_active <= m_pending;
      if (cfg_we) m_pending <= int'(cfg_wdata);
      m_cnt <= (m_cnt + 1) % 128;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cnt %0d)", tag, what, act, exp, m_cnt);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (checking && rst_n) begin
      check("R6 readback", int'(cfg_rdata), m_active);
      for (int ch = 0; ch < 4; ch++) begin
        int n;
        int per;
        int es;
        int eq;
        n   = (m_active / (1 << (3 * ch))) % 8;  // R2 field position
        per = 1 << n;
        es  = ((m_cnt % per) == per - 1) ? 1 : 0;
        eq  = (n == 0) ? 0 : ((m_cnt / (per / 2)) % 2);
        check((n == 0) ? "R4 strobe" : "R3 strobe", int'(strobe[ch]), es);
        check((n == 0) ? "R4 square" : "R5 square", int'(square[ch]), eq);
      end
      if (m_cnt == 127) check("R8 all strobes at 127", int'(strobe), 15);
    end
  end

  task automatic write_cfg(input logic [11:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    vectors   = 0;
    errors    = 0;
    checking  = 1'b0;
    done      = 1'b0;
    tag       = "R1";
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    run(4);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state in the first cycle after release
    check("R1 reset readback", int'(cfg_rdata), 2258);
    check("R1 strobes low", int'(strobe), 0);
    check("R1 squares low", int'(square), 0);
    checking = 1'b1;

    tag = "R3 R5 R8 default";
    run(300);

    tag = "R4 all zero selectors";
    write_cfg(12'o0000);
    run(300);

    tag = "R2 R9 mixed fields";
    write_cfg(12'o7650);
    run(300);

    tag = "R2 R9 single field change";
    write_cfg(12'o7150);
    run(300);

    // R6/R7: two writes inside one wrap window, last wins
    tag = "R7 last write wins";
    while (m_cnt != 10) @(negedge clk);
    write_cfg(12'o1234);
    write_cfg(12'o4321);
    check("R6 readback still old", int'(cfg_rdata), 12'o7150);
    run(130);
    check("R7 readback after wrap", int'(cfg_rdata), 12'o4321);

    // R6: write landing on the wrap edge waits a full window
    tag = "R6 write at wrap edge";
    while (m_cnt != 126) @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 12'o0777;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6 not applied at same wrap", int'(cfg_rdata), 12'o4321);
    run(200);
    check("R6 applied at next wrap", int'(cfg_rdata), 12'o0777);

    tag = "R3 R5 slowest";
    write_cfg(12'o7777);
    run(400);

    checking = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule